// File: doc/BRIEF.md
# Strided 2-D Region Address Walker

This block walks a rectangular region held in a flat, one-dimensional on-chip buffer of fixed depth and produces the linear address of every element of that region. Software describes each region with four numbers: the base address of the first element, the number of elements per row, the number of rows, and the pitch between the first elements of consecutive rows. Because the pitch is independent of the row length, a sub-rectangle can sit anywhere in the buffer. Two images, or the two halves of a double buffer, can share one memory simply by giving them different base addresses.

A descriptor is offered on a valid/ready handshake. The block checks it against the buffer depth before emitting anything. It then issues one address per accepted cycle in row-major order, with a flag on the last element of each row and another on the last element of the region. The consumer can stall the stream at any time with a ready signal. Completion and rejection are each reported by a one-cycle pulse.

Top module: `b2d_addr_gen`

## Requirements
- R1: While reset is held and in the first cycle after it is released, `desc_ready` is 1 and `addr_valid`, `done` and `err` are 0.
- R2: A descriptor is taken on a rising edge where `desc_valid` and `desc_ready` are both 1. For a legal descriptor, `addr_valid` rises in the next cycle with `addr_out` equal to the base address. `desc_ready` stays 0 for as long as `addr_valid` is 1.
- R3: The address for row r (counted from 0) and column c (counted from 0) equals base + r × pitch + c. Addresses are emitted in row-major order, and columns within a row step by exactly one.
- R4: `addr_eol` is 1 exactly on the address whose column is the last column of its row.
- R5: `addr_eor` is 1 only on the final address of the region, where `addr_eol` is also 1. `done` is a one-cycle pulse in the cycle after the handshake of that final address.
- R6: While `addr_valid` is 1 and `addr_ready` is 0, `addr_out`, `addr_eol` and `addr_eor` hold their values, and the walk advances only on a cycle where both are 1.
- R7: A descriptor whose row length exceeds its pitch is rejected. `err` pulses for one cycle in the cycle after acceptance, and no address is emitted.
- R8: A descriptor whose last address, base + (rows − 1) × pitch + (row length − 1), is BUF_N or more is rejected in the same way as in R7. A last address of exactly BUF_N − 1 is legal.
- R9: A descriptor with a row length or a row count of zero is completed at once. `done` pulses in the cycle after acceptance, `err` stays 0, and no address is emitted. This check has priority over R7 and R8.
- R10: Every emitted address is below BUF_N.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| desc_valid | input | 1 | Descriptor offered |
| desc_ready | output | 1 | Block idle and able to take a descriptor |
| desc_base | input | ADDR_W | Address of the first element of the region |
| desc_len | input | DIM_W | Elements per row |
| desc_rows | input | DIM_W | Number of rows |
| desc_pitch | input | DIM_W | Address distance between the starts of consecutive rows |
| addr_valid | output | 1 | `addr_out` holds a pending address |
| addr_ready | input | 1 | Consumer accepts the pending address |
| addr_out | output | ADDR_W | Linear buffer address |
| addr_eol | output | 1 | Pending address is the last one in its row |
| addr_eor | output | 1 | Pending address is the last one in the region |
| done | output | 1 | One-cycle pulse when a region has finished |
| err | output | 1 | One-cycle pulse when a descriptor is rejected |

## Verification
Every result of this block is due a fixed number of edges after its cause. The first address, or the `done` or `err` pulse of an empty or rejected descriptor, appears one edge after the accepting edge. Each following address appears one edge after the handshake that consumed its predecessor, and `done` appears one edge after the final handshake. The bench changes `addr_ready` shortly after each rising edge and samples every output at the falling edge, so a handshake seen at a falling edge is the one the design takes at the next rising edge. The scoreboard pops exactly one expected entry per such handshake. The descriptor task checks the acceptance result at the first falling edge after the accepting edge, and checks again one cycle later that a rejected or empty descriptor produced no address.

// File: rtl/b2d_pkg.sv
package b2d_pkg;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_RUN  = 1'b1
  } b2d_state_e;

  typedef enum logic [1:0] {
    V_RUN   = 2'd0,
    V_EMPTY = 2'd1,
    V_BAD   = 2'd2
  } b2d_verdict_e;

endpackage

// File: rtl/b2d_desc_check.sv
module b2d_desc_check
  import b2d_pkg::*;
#(
  parameter int BUF_N  = 1000,
  parameter int ADDR_W = $clog2(BUF_N),
  parameter int DIM_W  = 10
) (
  input  logic [ADDR_W-1:0] base,
  input  logic [DIM_W-1:0]  len,
  input  logic [DIM_W-1:0]  rows,
  input  logic [DIM_W-1:0]  pitch,
  output b2d_verdict_e      verdict
);
  localparam int SPAN_W = ADDR_W + 2 * DIM_W + 1;

  logic [DIM_W-1:0]  rows_m1;
  logic [DIM_W-1:0]  len_m1;
  logic [SPAN_W-1:0] last_addr;

  always_comb begin
    rows_m1   = rows - DIM_W'(1);
    len_m1    = len - DIM_W'(1);
    last_addr = SPAN_W'(base) + SPAN_W'(rows_m1) * SPAN_W'(pitch) + SPAN_W'(len_m1);
    if (len == '0 || rows == '0)
      verdict = V_EMPTY;
    else if (len > pitch || last_addr >= SPAN_W'(BUF_N))
      verdict = V_BAD;
    else
      verdict = V_RUN;
  end

endmodule

// File: rtl/b2d_walker.sv
module b2d_walker #(
  parameter int ADDR_W = 10,
  parameter int DIM_W  = 10
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic              adv,
  input  logic [ADDR_W-1:0] base,
  input  logic [DIM_W-1:0]  len,
  input  logic [DIM_W-1:0]  rows,
  input  logic [DIM_W-1:0]  pitch,
  output logic [ADDR_W-1:0] addr,
  output logic              eol,
  output logic              eor
);
  logic [DIM_W-1:0]  col_q, row_q, col_last_q, row_last_q;
  logic [ADDR_W-1:0] pitch_q, row_base_q, addr_q, next_row_base;

  assign next_row_base = row_base_q + pitch_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      col_q      <= '0;
      row_q      <= '0;
      col_last_q <= '0;
      row_last_q <= '0;
      pitch_q    <= '0;
      row_base_q <= '0;
      addr_q     <= '0;
    end else if (load) begin
      col_q      <= '0;
      row_q      <= '0;
      col_last_q <= len - DIM_W'(1);
      row_last_q <= rows - DIM_W'(1);
      pitch_q    <= ADDR_W'(pitch);
      row_base_q <= base;
      addr_q     <= base;
    end else if (adv) begin
      if (col_q == col_last_q) begin
        col_q      <= '0;
        row_q      <= row_q + DIM_W'(1);
        row_base_q <= next_row_base;
        addr_q     <= next_row_base;
      end else begin
        col_q  <= col_q + DIM_W'(1);
        addr_q <= addr_q + ADDR_W'(1);
      end
    end
  end

  assign addr = addr_q;
  assign eol  = (col_q == col_last_q);
  assign eor  = (col_q == col_last_q) && (row_q == row_last_q);

endmodule

// File: rtl/b2d_addr_gen.sv
module b2d_addr_gen
  import b2d_pkg::*;
#(
  parameter int BUF_N  = 1000,
  parameter int ADDR_W = $clog2(BUF_N),
  parameter int DIM_W  = 10
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              desc_valid,
  output logic              desc_ready,
  input  logic [ADDR_W-1:0] desc_base,
  input  logic [DIM_W-1:0]  desc_len,
  input  logic [DIM_W-1:0]  desc_rows,
  input  logic [DIM_W-1:0]  desc_pitch,
  output logic              addr_valid,
  input  logic              addr_ready,
  output logic [ADDR_W-1:0] addr_out,
  output logic              addr_eol,
  output logic              addr_eor,
  output logic              done,
  output logic              err
);
  b2d_state_e   state_q;
  b2d_verdict_e verdict;
  logic         valid_q, done_q, err_q;
  logic         accept, advance, load;

  b2d_desc_check #(.BUF_N(BUF_N), .ADDR_W(ADDR_W), .DIM_W(DIM_W)) u_check (
    .base(desc_base), .len(desc_len), .rows(desc_rows), .pitch(desc_pitch),
    .verdict(verdict)
  );

  assign desc_ready = (state_q == ST_IDLE);
  assign accept     = desc_valid && desc_ready;
  assign load       = accept && (verdict == V_RUN);
  assign advance    = valid_q && addr_ready;

  b2d_walker #(.ADDR_W(ADDR_W), .DIM_W(DIM_W)) u_walk (
    .clk(clk), .rst(rst), .load(load), .adv(advance),
    .base(desc_base), .len(desc_len), .rows(desc_rows), .pitch(desc_pitch),
    .addr(addr_out), .eol(addr_eol), .eor(addr_eor)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_IDLE;
      valid_q <= 1'b0;
      done_q  <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      done_q <= 1'b0;
      err_q  <= 1'b0;
      case (state_q)
        ST_IDLE: if (accept) begin
          case (verdict)
            V_RUN: begin
              state_q <= ST_RUN;
              valid_q <= 1'b1;
            end
            V_EMPTY: done_q <= 1'b1;
            default: err_q  <= 1'b1;
          endcase
        end
        ST_RUN: if (advance && addr_eor) begin
          state_q <= ST_IDLE;
          valid_q <= 1'b0;
          done_q  <= 1'b1;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign addr_valid = valid_q;
  assign done       = done_q;
  assign err        = err_q;

endmodule

// File: rtl/b2d_addr_gen_sva.sv
module b2d_addr_gen_sva #(
  parameter int BUF_N  = 1000,
  parameter int ADDR_W = $clog2(BUF_N)
) (
  input logic              clk,
  input logic              rst,
  input logic              desc_valid,
  input logic              desc_ready,
  input logic              addr_valid,
  input logic              addr_ready,
  input logic [ADDR_W-1:0] addr_out,
  input logic              addr_eol,
  input logic              addr_eor,
  input logic              done,
  input logic              err
);
  localparam logic [ADDR_W:0] LIMIT = (ADDR_W + 1)'(BUF_N);

  a_r10_in_range: assert property (@(posedge clk) disable iff (rst)
    addr_valid |-> ({1'b0, addr_out} < LIMIT));

  a_r6_hold: assert property (@(posedge clk) disable iff (rst)
    addr_valid && !addr_ready |=> addr_valid && $stable(addr_out) && $stable(addr_eol) && $stable(addr_eor));

  a_r5_eor_in_eol: assert property (@(posedge clk) disable iff (rst)
    addr_valid && addr_eor |-> addr_eol);

  a_r2_busy: assert property (@(posedge clk) disable iff (rst)
    addr_valid |-> !desc_ready);

  a_r3_col_step: assert property (@(posedge clk) disable iff (rst)
    addr_valid && addr_ready && !addr_eol |=> addr_valid && (addr_out == $past(addr_out) + ADDR_W'(1)));

  a_r5_done_cause: assert property (@(posedge clk) disable iff (rst)
    done |-> $past(addr_valid && addr_ready && addr_eor) || $past(desc_valid && desc_ready));

  a_r7_excl: assert property (@(posedge clk) disable iff (rst)
    !(done && err) && !(err && addr_valid));

endmodule

bind b2d_addr_gen b2d_addr_gen_sva #(.BUF_N(BUF_N), .ADDR_W(ADDR_W)) u_sva (
  .clk(clk), .rst(rst), .desc_valid(desc_valid), .desc_ready(desc_ready),
  .addr_valid(addr_valid), .addr_ready(addr_ready), .addr_out(addr_out),
  .addr_eol(addr_eol), .addr_eor(addr_eor), .done(done), .err(err)
);

// File: tb/sim_b2d_addr_gen.sv
`timescale 1ns/1ps
module sim_b2d_addr_gen;
  localparam int BUF_N  = 1000;
  localparam int ADDR_W = 10;
  localparam int DIM_W  = 10;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              desc_valid = 1'b0;
  logic              desc_ready;
  logic [ADDR_W-1:0] desc_base = '0;
  logic [DIM_W-1:0]  desc_len = '0, desc_rows = '0, desc_pitch = '0;
  logic              addr_valid;
  logic              addr_ready = 1'b1;
  logic [ADDR_W-1:0] addr_out;
  logic              addr_eol, addr_eor, done, err;

  typedef struct packed {
    logic [ADDR_W-1:0] a;
    logic              eol;
    logic              eor;
  } exp_t;

  exp_t q[$];
  int   n_checks = 0;
  int   n_fail   = 0;
  int   bp_mode  = 0;
  int   cyc      = 0;
  logic hold_pend = 1'b0;
  exp_t hold_val;

  always #10 clk = ~clk;

  b2d_addr_gen #(.BUF_N(BUF_N), .ADDR_W(ADDR_W), .DIM_W(DIM_W)) u0 (
    .clk(clk), .rst(rst), .desc_valid(desc_valid), .desc_ready(desc_ready),
    .desc_base(desc_base), .desc_len(desc_len), .desc_rows(desc_rows),
    .desc_pitch(desc_pitch), .addr_valid(addr_valid), .addr_ready(addr_ready),
    .addr_out(addr_out), .addr_eol(addr_eol), .addr_eor(addr_eor),
    .done(done), .err(err)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  endtask

  // consumer ready, changed just after each rising edge
  initial forever begin
    @(posedge clk);
    #2;
    cyc++;
    addr_ready = (bp_mode == 0) ? 1'b1 : ((cyc % 3) != 0) && ((cyc % 7) != 0);
  end

  // monitor / scoreboard
  always @(negedge clk) begin
    if (!rst) begin
      if (hold_pend) begin
        check(addr_valid && addr_out == hold_val.a && addr_eol == hold_val.eol
              && addr_eor == hold_val.eor, "R6 hold", int'(addr_out), int'(hold_val.a));
        hold_pend = 1'b0;
      end
      if (addr_valid) begin
        check(!desc_ready, "R2 busy", int'(desc_ready), 0);
        check(int'(addr_out) < BUF_N, "R10 range", int'(addr_out), BUF_N - 1);
        if (addr_ready) begin
          if (q.size() == 0) begin
            check(1'b0, "R3 unexpected address", int'(addr_out), -1);
          end else begin
            exp_t e;
            e = q.pop_front();
            check(addr_out == e.a, "R3 address", int'(addr_out), int'(e.a));
            check(addr_eol == e.eol, "R4 eol", int'(addr_eol), int'(e.eol));
            check(addr_eor == e.eor, "R5 eor", int'(addr_eor), int'(e.eor));
          end
        end else begin
          hold_pend = 1'b1;
          hold_val  = '{a: addr_out, eol: addr_eol, eor: addr_eor};
        end
      end
    end
  end

  // kind: 0 normal, 1 empty, 2 rejected
  task automatic run_region(input int b, input int w, input int h, input int p,
                            input int kind, input string req);
    int guard;
    if (kind == 0)
      for (int r = 0; r < h; r++)
        for (int c = 0; c < w; c++)
          q.push_back('{a: ADDR_W'(b + r * p + c), eol: (c == w - 1),
                        eor: (c == w - 1) && (r == h - 1)});
    @(negedge clk);
    desc_base  = ADDR_W'(b);
    desc_len   = DIM_W'(w);
    desc_rows  = DIM_W'(h);
    desc_pitch = DIM_W'(p);
    desc_valid = 1'b1;
    check(desc_ready, {req, " idle before"}, int'(desc_ready), 1);
    @(negedge clk);
    desc_valid = 1'b0;
    if (kind == 0) begin
      check(addr_valid && addr_out == ADDR_W'(b), "R2 first address", int'(addr_out), b);
      guard = 0;
      while (!done && guard < 20000) begin
        @(negedge clk);
        guard++;
      end
      check(done, "R5 done pulse", int'(done), 1);
      check(q.size() == 0, "R5 all addresses consumed", q.size(), 0);
      check(!addr_valid && desc_ready, "R5 idle after done", int'(addr_valid), 0);
      @(negedge clk);
      check(!done, "R5 done one cycle", int'(done), 0);
    end else begin
      if (kind == 1)
        check(done && !err && !addr_valid, {req, " immediate done"}, int'(done), 1);
      else
        check(err && !done && !addr_valid, {req, " error pulse"}, int'(err), 1);
      @(negedge clk);
      check(!addr_valid && !done && !err, {req, " nothing emitted"}, int'(addr_valid), 0);
    end
  endtask

  initial begin
    repeat (5) @(posedge clk);
    #1;
    check(desc_ready && !addr_valid && !done && !err, "R1 in reset", int'(addr_valid), 0);
    @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check(desc_ready && !addr_valid && !done && !err, "R1 after reset", int'(desc_ready), 1);

    run_region(10, 4, 3, 6, 0, "R3");      // strided sub-rectangle
    run_region(20, 8, 2, 8, 0, "R3");      // contiguous rows
    run_region(5, 1, 5, 3, 0, "R4");       // single column
    run_region(42, 1, 1, 1, 0, "R5");      // single element
    bp_mode = 1;
    run_region(100, 5, 4, 9, 0, "R6");     // stalls
    run_region(0, 6, 3, 16, 0, "R6");      // ping half
    run_region(500, 6, 3, 16, 0, "R6");    // pong half
    bp_mode = 0;
    run_region(996, 4, 1, 4, 0, "R8");     // last address 999
    run_region(0, 0, 3, 5, 1, "R9");       // zero length
    run_region(7, 4, 0, 5, 1, "R9");       // zero rows
    run_region(9, 0, 0, 0, 1, "R9");       // zero beats bad pitch
    run_region(0, 6, 2, 4, 2, "R7");       // length > pitch
    run_region(0, 6, 1, 4, 2, "R7");       // length > pitch, one row
    run_region(997, 4, 1, 4, 2, "R8");     // last address 1000
    run_region(900, 10, 3, 50, 2, "R8");   // last address 1009
    run_region(30, 3, 2, 5, 0, "R2");      // still works after rejects
    finish_run();
  end

  initial begin
    repeat (150000) @(posedge clk);
    check(1'b0, "watchdog", cyc, 0);
    finish_run();
  end

endmodule